// File: doc/BRIEF.md
# ADC Sample Format Converter

This block is one per-channel stage in a converter receive path. It takes raw samples of a configurable resolution and returns a byte-aligned two's complement sample for the processing that follows. The input may be offset binary or two's complement. Two's complement samples can be sign-extended to the next multiple of eight bits. Conversion can also be switched off, in which case the sample passes through with zero padding.

The format controls are not applied continuously. They are taken into the channel only at the clock where the channel enable goes from low to high. A sample accepted in that same clock already uses the new settings. Any later change to the controls has no effect until the enable falls and rises again.

Output data and output valid come from registers, one clock after the input. While the channel is disabled, no output sample is produced.

Top module: `adc_fmt_conv`

## Requirements
- R1: While reset is held low at a clock edge, out_valid is 0 and out_data is all zeros after that edge.
- R2: out_valid equals (in_valid AND chan_en) from the previous clock. out_data carries the converted sample accepted in that clock. When no sample is accepted, out_data keeps its value.
- R3: A sample presented while chan_en is 0 is dropped. out_valid is 0 in the next clock and out_data is unchanged.
- R4: With the captured fmt_en at 0, out_data is in_data, zero-extended to OUT_W = 8*ceil(DATA_W/8) bits (16 bits for the default 14-bit input).
- R5: With fmt_en at 1 and fmt_offbin at 1 (offset binary input), bit DATA_W-1 of the sample is inverted, the lower bits are passed unchanged, and the padding bits are 0.
- R6: With fmt_en at 1, fmt_offbin at 0 (two's complement input) and fmt_sext at 1, every padding bit from DATA_W up to OUT_W-1 equals bit DATA_W-1 of the input.
- R7: With fmt_en at 1, fmt_offbin at 0 and fmt_sext at 0, the sample is passed unchanged and the padding bits are 0.
- R8: In offset binary mode, fmt_sext has no effect. The padding bits stay 0 even when fmt_sext is 1.
- R9: fmt_en, fmt_offbin and fmt_sext are captured only in the clock where chan_en is 1 and was 0 in the previous clock. A sample accepted in that clock uses the new values. Changes made while chan_en stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable; a rising edge loads the format controls |
| fmt_en | input | 1 | Conversion enable (0 = raw pass-through) |
| fmt_offbin | input | 1 | Input type: 1 = offset binary, 0 = two's complement |
| fmt_sext | input | 1 | Sign-extension enable, used in two's complement mode only |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W | Raw input sample |
| out_valid | output | 1 | Output sample qualifier, one clock after the input |
| out_data | output | OUT_W | Converted, byte-aligned sample |

## Verification
The assertions treat chan_en and the format inputs as levels sampled once per clock, with no timing relation between them. They expect in_data to be at known values whenever in_valid is high. The bench changes every input on the falling clock edge, so each one is stable at the sampling edge. It also sends samples in the same clock as an enable rise, to cover the case where new settings are loaded and used in one clock. The format inputs are changed in mid-run, both with the enable held high and after it has fallen and risen again.

// File: rtl/fmtconv_pkg.sv
// Package: shared types and width helpers for the sample format converter.
// Assumes: widths are positive; OUT_W rounds the input width up to a byte.
package fmtconv_pkg;

    // Format controls held per channel.
    typedef struct packed {
        logic en;       // conversion enable
        logic offbin;   // 1: offset binary input, 0: two's complement
        logic sext;     // sign-extension enable (two's complement only)
    } fmt_ctrl_t;

    // Round a bit count up to the next multiple of eight.
    function automatic int byte_ceil(input int bits);
        return ((bits + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/fmtconv_ctrl_capture.sv
// Module: fmtconv_ctrl_capture
// Loads the format controls on a rising edge of the channel enable and holds
// them until the next rising edge. During the rising-edge clock, the incoming
// values are passed straight through, so a sample accepted in that clock
// already sees them. Assumes chan_en is synchronous to clk.
module fmtconv_ctrl_capture
    import fmtconv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chan_en,
    input  fmt_ctrl_t ctl_in,
    output fmt_ctrl_t ctl_eff
);

    logic      en_q;
    fmt_ctrl_t held;
    logic      rise;

    assign rise = chan_en & ~en_q;

    // Track the previous enable and load the controls on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            held <= '0;
        end else begin
            en_q <= chan_en;
            if (rise) begin
                held <= ctl_in;
            end
        end
    end

    // Settings in force for the sample accepted in this clock.
    always_comb begin
        ctl_eff = rise ? ctl_in : held;
    end

    // R9: while the enable stays high, the settings in force do not move.
    assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en ##1 chan_en) |-> $stable(ctl_eff));

endmodule

// File: rtl/fmtconv_core.sv
// Module: fmtconv_core
// Combinational conversion of one raw sample into a byte-aligned two's
// complement word. Offset binary input has its top bit inverted. Two's
// complement input may be sign-extended. Every other case pads with zeros.
// Assumes DATA_W >= 2.
module fmtconv_core
    import fmtconv_pkg::*;
#(
    parameter int DATA_W = 14,
    localparam int OUT_W = byte_ceil(DATA_W)
) (
    input  fmt_ctrl_t         ctl,
    input  logic [DATA_W-1:0] raw,
    output logic [OUT_W-1:0]  conv
);

    localparam int PAD_W = OUT_W - DATA_W;
    localparam int MSB   = DATA_W - 1;

    logic [DATA_W-1:0] body;
    logic              sext_on;

    // Invert the top bit for offset binary input when conversion is enabled.
    always_comb begin
        body = raw;
        if (ctl.en && ctl.offbin) begin
            body[MSB] = ~raw[MSB];
        end
        sext_on = ctl.en && !ctl.offbin && ctl.sext;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            // Fill the padding with copies of the sign bit or with zeros.
            always_comb begin
                conv = {(sext_on ? {PAD_W{raw[MSB]}} : {PAD_W{1'b0}}), body};
            end
        end else begin : g_nopad
            // Already byte aligned: no padding.
            always_comb begin
                conv = body;
            end
        end
    endgenerate

endmodule

// File: rtl/fmtconv_outreg.sv
// Module: fmtconv_outreg
// Output stage: registers the valid flag on every clock and the data only
// when a sample is accepted. Otherwise the last data word is held.
module fmtconv_outreg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [WIDTH-1:0] d_in,
    output logic             q_valid,
    output logic [WIDTH-1:0] q_data
);

    // One-clock pipeline register with hold on idle clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= accept;
            if (accept) begin
                q_data <= d_in;
            end
        end
    end

endmodule

// File: rtl/adc_fmt_conv.sv
// Module: adc_fmt_conv (top)
// Per-channel sample format converter with a fixed one-clock latency. The
// format controls are loaded on a rising edge of chan_en. Samples are only
// accepted while chan_en is high. Assumes all inputs are synchronous to clk
// and that the reset is synchronous and active low.
module adc_fmt_conv
    import fmtconv_pkg::*;
#(
    parameter int DATA_W = 14,
    localparam int OUT_W = byte_ceil(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              fmt_en,
    input  logic              fmt_offbin,
    input  logic              fmt_sext,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    localparam int MSB = DATA_W - 1;

    fmt_ctrl_t         ctl_req;
    fmt_ctrl_t         ctl_eff;
    logic [OUT_W-1:0]  conv;
    logic              accept;

    // Gather the control pins and derive the sample-accept strobe.
    always_comb begin
        ctl_req = '{en: fmt_en, offbin: fmt_offbin, sext: fmt_sext};
        accept  = in_valid & chan_en;
    end

    fmtconv_ctrl_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .ctl_in  (ctl_req),
        .ctl_eff (ctl_eff)
    );

    fmtconv_core #(.DATA_W(DATA_W)) u_core (
        .ctl  (ctl_eff),
        .raw  (in_data),
        .conv (conv)
    );

    fmtconv_outreg #(.WIDTH(OUT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .d_in    (conv),
        .q_valid (out_valid),
        .q_data  (out_data)
    );

    // R2: an accepted sample shows up as valid one clock later.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_en) |=> out_valid);

    // R2: idle clocks leave the output data untouched.
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && chan_en) |=> (!out_valid && $stable(out_data)));

    // R3: a disabled channel never produces a valid sample.
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !out_valid);

    // R5: offset binary input leaves with its top sample bit flipped.
    assert_offbin_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_en && ctl_eff.en && ctl_eff.offbin)
        |=> (out_data[MSB] != $past(in_data[MSB])));

    // R4: with conversion off, the sample body is copied unchanged.
    assert_raw_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_en && !ctl_eff.en)
        |=> (out_data[MSB:0] == $past(in_data)));

    generate
        if (OUT_W > DATA_W) begin : g_pad_chk
            // R6: sign extension copies the input sign into the top bit.
            assert_sext_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && chan_en && ctl_eff.en && !ctl_eff.offbin && ctl_eff.sext)
                |=> (out_data[OUT_W-1] == $past(in_data[MSB])));

            // R7 R8: without sign extension the padding is all zeros.
            assert_zero_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && chan_en && !(ctl_eff.en && !ctl_eff.offbin && ctl_eff.sext))
                |=> (out_data[OUT_W-1:DATA_W] == '0));
        end
    endgenerate

endmodule

// File: tb/tb_adc_fmt_conv.sv
// Directed bench for adc_fmt_conv with a 14-bit input and a 16-bit output.
// Inputs are driven on the falling edge and outputs sampled on the next one.
module tb_adc_fmt_conv;

    localparam int DW = 14;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0;
    logic          fmt_en = 1'b0;
    logic          fmt_offbin = 1'b0;
    logic          fmt_sext = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_fmt_conv #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fmt_en(fmt_en),
        .fmt_offbin(fmt_offbin), .fmt_sext(fmt_sext), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    // Reference conversion written from the requirements.
    function automatic logic [OW-1:0] model(input logic [DW-1:0] raw,
                                            input bit en, input bit ob, input bit se);
        logic [OW-1:0] r;
        r = {2'b00, raw};
        if (en && ob) r[13] = ~r[13];
        else if (en && se && raw[13]) r[15:14] = 2'b11;
        return r;
    endfunction

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drop the enable for one clock, then raise it with new settings.
    task automatic configure(input bit en, input bit ob, input bit se);
        @(negedge clk);
        chan_en = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chan_en = 1'b1; fmt_en = en; fmt_offbin = ob; fmt_sext = se;
    endtask

    // Present one sample and check the registered result one clock later.
    task automatic send(input string req, input logic [DW-1:0] d, input logic [OW-1:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {15'd0, out_valid}, 16'd1);
        check({req, " data"}, out_data, exp);
    endtask

    task automatic t_reset;
        chan_en = 1'b1; in_valid = 1'b1; in_data = 14'h3FFF;
        repeat (3) @(negedge clk);
        check("R1 valid", {15'd0, out_valid}, 16'd0);
        check("R1 data", out_data, 16'h0000);
        chan_en = 1'b0; in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_passthrough;
        configure(1'b0, 1'b1, 1'b1);
        send("R4", 14'h2ABC, 16'h2ABC);
        send("R4", 14'h3FFF, 16'h3FFF);
    endtask

    task automatic t_offbin;
        configure(1'b1, 1'b1, 1'b1);
        send("R5", 14'h0000, 16'h2000);
        send("R5", 14'h3FFF, 16'h1FFF);
        send("R8", 14'h2000, 16'h0000);
        send("R8", 14'h2345, model(14'h2345, 1, 1, 1));
    endtask

    task automatic t_twos;
        configure(1'b1, 1'b0, 1'b1);
        send("R6", 14'h2001, 16'hE001);
        send("R6", 14'h1FFF, 16'h1FFF);
        configure(1'b1, 1'b0, 1'b0);
        send("R7", 14'h2001, 16'h2001);
        send("R7", 14'h3FFF, 16'h3FFF);
    endtask

    task automatic t_valid_timing;
        configure(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b1; in_data = 14'h3000;
        @(negedge clk);
        check("R2 valid on", {15'd0, out_valid}, 16'd1);
        check("R2 data", out_data, 16'hF000);
        in_valid = 1'b0; in_data = 14'h0123;
        @(negedge clk);
        check("R2 valid off", {15'd0, out_valid}, 16'd0);
        check("R2 hold", out_data, 16'hF000);
    endtask

    task automatic t_disabled;
        @(negedge clk);
        chan_en = 1'b0; in_valid = 1'b1; in_data = 14'h0555;
        @(negedge clk);
        check("R3 valid", {15'd0, out_valid}, 16'd0);
        check("R3 data", out_data, 16'hF000);
        in_valid = 1'b0;
    endtask

    task automatic t_capture;
        configure(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        fmt_offbin = 1'b1; fmt_sext = 1'b0; fmt_en = 1'b1;
        send("R9 ignored", 14'h2001, 16'hE001);
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
        chan_en = 1'b1; fmt_en = 1'b1; fmt_offbin = 1'b1; fmt_sext = 1'b0;
        in_valid = 1'b1; in_data = 14'h2001;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 rise valid", {15'd0, out_valid}, 16'd1);
        check("R9 rise data", out_data, 16'h0001);
    endtask

    initial begin
        t_reset;
        t_passthrough;
        t_offbin;
        t_twos;
        t_valid_timing;
        t_disabled;
        t_capture;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule